// File: doc/BRIEF.md
# Outbound Transaction Termination Handler

This block stands between an internal system bus and the initiator side of a PCI-style bridge. Each internal request first passes through window decode. A request that lands in no mapped window ends at once with a bus error. So does a 16-byte burst aimed at a window marked as I/O space. Any other request is handed to the PCI initiator, and the block then waits for the code that reports how the PCI cycle ended.

A master abort is not treated as a failure. The internal transaction completes normally, and a read returns all ones. Target abort and an exhausted retry budget end with a bus error. A retry that still has budget left sends the cycle out again without answering the internal bus.

Every outcome that is not normal sets a sticky status bit, and software clears these bits by writing ones. Two interrupt lines come from the status bits. One serves the PCI controller and reflects master abort only. The other is a system-level error line that gathers every bus-error cause.

Top module: `obt_term_unit`

## Requirements
- R1: After reset the status vector is zero, and `rsp_valid`, `issue_valid`, `pci_irq` and `sys_err_irq` are all low.
- R2: A request accepted while idle is decoded against windows, where window i matches when `((req_addr ^ base_i) & ~mask_i) == 0`. On a match, `issue_valid` pulses in the next cycle and no response is given. With no match, the next cycle carries `rsp_valid` with `rsp_err` high, and status bit 3 (no-hit) is set.
- R3: A request with `req_burst` high that matches a window whose `win_mem` bit is 0 ends in the next cycle with `rsp_err` high and sets status bit 4 (unsupported). A non-burst request to such a window, or a burst to a memory window, is issued normally.
- R4: Termination code 0 (normal) gives `rsp_valid` with `rsp_err` low in the cycle after `term_valid`. `rsp_rdata` equals `pci_rdata` for reads and is zero for writes.
- R5: Termination code 1 (master abort) gives `rsp_err` low, `rsp_rdata` of 0xFFFFFFFF for a read (zero for a write), and sets status bit 0.
- R6: Termination code 2 (target abort) gives `rsp_err` high and sets status bit 1.
- R7: Termination code 3 (retry) decrements a counter that is loaded from `retry_limit` when a request is accepted. For a limit L of at least 1, the first L-1 retries re-pulse `issue_valid` with no response. The L-th retry ends with `rsp_err` high and sets status bit 2. The counter reloads for every new request.
- R8: Status bits are sticky. A cycle with `clr_valid` high clears the bits set in `clr_mask`. A bit being set in the same cycle stays set.
- R9: `pci_irq` is status bit 0 AND `irq_en` bit 0. `sys_err_irq` is the OR of status bits 1 to 4, each ANDed with its `irq_en` bit. An unsupported burst therefore never raises `pci_irq`.
- R10: Each request receives exactly one response. `req_valid` is ignored while a request is outstanding, and `term_valid` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request strobe |
| req_addr | input | AW | Internal request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 16-byte burst request |
| win_base | input | NWIN*AW | Window base addresses, window i at bits [i*AW +: AW] |
| win_mask | input | NWIN*AW | Window offset masks (ones mark offset bits) |
| win_mem | input | NWIN | 1 = memory window, 0 = I/O window |
| retry_limit | input | RW | Retry budget loaded per request |
| term_valid | input | 1 | Termination code strobe from the PCI initiator |
| term_code | input | 2 | 0 normal, 1 master abort, 2 target abort, 3 retry |
| pci_rdata | input | 32 | Read data from the PCI cycle |
| irq_en | input | 5 | Interrupt enable per status bit |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| issue_valid | output | 1 | Start (or restart) a PCI cycle |
| rsp_valid | output | 1 | Internal bus completion strobe |
| rsp_err | output | 1 | Completion is a bus error |
| rsp_rdata | output | 32 | Read data returned to the internal bus |
| status | output | 5 | Sticky status: 0 MA, 1 TA, 2 retry, 3 no-hit, 4 unsupported |
| pci_irq | output | 1 | PCI controller interrupt request |
| sys_err_irq | output | 1 | System-level error interrupt request |

## Verification
If the idle/wait phase is wrong, the result shows on the next edge as one of three faults: a missing response, a second response, or a stray `issue_valid` when the next strobe is ignored or accepted. If the retry counter holds a wrong count, the error appears one retry early or late, so the fault is visible on the exact retry where the bench expects the bus error. Status bits that fail to stick or fail to clear are seen on the following cycle at `status` and at both interrupt lines. Those lines are combinational views of the status register.

// File: rtl/obt_pkg.sv
package obt_pkg;

    localparam int DATA_W = 32;
    localparam int ST_W   = 5;

    localparam int ST_MA     = 0;
    localparam int ST_TA     = 1;
    localparam int ST_RETRY  = 2;
    localparam int ST_NOHIT  = 3;
    localparam int ST_UNSUP  = 4;

    typedef enum logic [1:0] {
        TERM_OK     = 2'd0,
        TERM_MABORT = 2'd1,
        TERM_TABORT = 2'd2,
        TERM_RETRY  = 2'd3
    } term_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    function automatic logic sys_irq_of(input logic [ST_W-1:0] st,
                                        input logic [ST_W-1:0] en);
        logic [ST_W-1:0] hot;
        hot = st & en;
        return |hot[ST_W-1:ST_TA];
    endfunction

endpackage

// File: rtl/obt_win_decode.sv
module obt_win_decode #(
    parameter int NWIN = 4,
    parameter int AW   = 32
) (
    input  logic [AW-1:0]      addr,
    input  logic [NWIN*AW-1:0] win_base,
    input  logic [NWIN*AW-1:0] win_mask,
    input  logic [NWIN-1:0]    win_mem,
    output logic               hit,
    output logic               hit_mem
);
    logic [NWIN-1:0] match;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign match[i] = (((addr ^ win_base[i*AW +: AW]) & ~win_mask[i*AW +: AW]) == '0);
    end

    // lowest index wins when windows overlap
    always_comb begin
        hit     = 1'b0;
        hit_mem = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_mem = win_mem[i];
            end
        end
    end
endmodule

// File: rtl/obt_retry_ctr.sv
module obt_retry_ctr #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [RW-1:0] limit,
    input  logic          dec,
    output logic          exhausted
);
    logic [RW-1:0] cnt_q;

    assign exhausted = dec && ((cnt_q == '0) || (cnt_q == RW'(1)));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= limit;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - RW'(1);
    end
endmodule

// File: rtl/obt_status_regs.sv
module obt_status_regs
    import obt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic            clr_valid,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] irq_en,
    output logic [ST_W-1:0] status,
    output logic            pci_irq,
    output logic            sys_err_irq
);
    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] clr_eff;

    assign clr_eff = clr_valid ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= (st_q & ~clr_eff) | set_vec;
    end

    assign status      = st_q;
    assign pci_irq     = st_q[ST_MA] & irq_en[ST_MA];
    assign sys_err_irq = sys_irq_of(st_q, irq_en);
endmodule

// File: rtl/obt_term_unit.sv
module obt_term_unit
    import obt_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int AW   = 32,
    parameter int RW   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic                  req_write,
    input  logic                  req_burst,
    input  logic [NWIN*AW-1:0]    win_base,
    input  logic [NWIN*AW-1:0]    win_mask,
    input  logic [NWIN-1:0]       win_mem,
    input  logic [RW-1:0]         retry_limit,
    input  logic                  term_valid,
    input  logic [1:0]            term_code,
    input  logic [DATA_W-1:0]     pci_rdata,
    input  logic [ST_W-1:0]       irq_en,
    input  logic                  clr_valid,
    input  logic [ST_W-1:0]       clr_mask,
    output logic                  issue_valid,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ST_W-1:0]       status,
    output logic                  pci_irq,
    output logic                  sys_err_irq
);
    phase_e          phase_q;
    logic            rd_q;
    logic            busy;
    logic            issue_q;
    rsp_t            rsp_q;
    term_e           code;
    logic            hit, hit_mem, exhausted;
    logic            accept, fire, bad_decode;
    logic [ST_W-1:0] set_vec;

    assign code       = term_e'(term_code);
    assign busy       = (phase_q == PH_WAIT);
    assign accept     = !busy && req_valid;
    assign fire       = busy && term_valid;
    assign bad_decode = !hit || (req_burst && !hit_mem);

    obt_win_decode #(.NWIN(NWIN), .AW(AW)) u_dec (
        .addr     (req_addr),
        .win_base (win_base),
        .win_mask (win_mask),
        .win_mem  (win_mem),
        .hit      (hit),
        .hit_mem  (hit_mem)
    );

    obt_retry_ctr #(.RW(RW)) u_retry (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .limit     (retry_limit),
        .dec       (fire && code == TERM_RETRY),
        .exhausted (exhausted)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[ST_NOHIT]  = accept && !hit;
        set_vec[ST_UNSUP]  = accept && hit && req_burst && !hit_mem;
        set_vec[ST_MA]     = fire && code == TERM_MABORT;
        set_vec[ST_TA]     = fire && code == TERM_TABORT;
        set_vec[ST_RETRY]  = fire && code == TERM_RETRY && exhausted;
    end

    obt_status_regs u_st (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (set_vec),
        .clr_valid   (clr_valid),
        .clr_mask    (clr_mask),
        .irq_en      (irq_en),
        .status      (status),
        .pci_irq     (pci_irq),
        .sys_err_irq (sys_err_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rd_q    <= 1'b0;
            issue_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            issue_q <= 1'b0;
            rsp_q   <= '0;
            if (accept) begin
                rd_q <= !req_write;
                if (bad_decode) begin
                    rsp_q.valid <= 1'b1;
                    rsp_q.err   <= 1'b1;
                end else begin
                    issue_q <= 1'b1;
                    phase_q <= PH_WAIT;
                end
            end else if (fire) begin
                unique case (code)
                    TERM_OK: begin
                        rsp_q.valid <= 1'b1;
                        rsp_q.data  <= rd_q ? pci_rdata : '0;
                        phase_q     <= PH_IDLE;
                    end
                    TERM_MABORT: begin
                        rsp_q.valid <= 1'b1;
                        rsp_q.data  <= rd_q ? '1 : '0;
                        phase_q     <= PH_IDLE;
                    end
                    TERM_TABORT: begin
                        rsp_q.valid <= 1'b1;
                        rsp_q.err   <= 1'b1;
                        phase_q     <= PH_IDLE;
                    end
                    TERM_RETRY: begin
                        if (exhausted) begin
                            rsp_q.valid <= 1'b1;
                            rsp_q.err   <= 1'b1;
                            phase_q     <= PH_IDLE;
                        end else begin
                            issue_q <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign issue_valid = issue_q;
    assign rsp_valid   = rsp_q.valid;
    assign rsp_err     = rsp_q.err;
    assign rsp_rdata   = rsp_q.data;
endmodule

// File: rtl/obt_checker.sv
module obt_checker
    import obt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              term_valid,
    input logic [1:0]        term_code,
    input logic              busy,
    input logic              rd_pending,
    input logic              clr_valid,
    input logic [ST_W-1:0]   clr_mask,
    input logic              issue_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ST_W-1:0]   status
);
    // R10: every response traces back to an accepted request or a termination
    assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && !busy) || $past(term_valid && busy)));

    // R10: never issue and respond in the same cycle
    assert_issue_rsp_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(issue_valid && rsp_valid));

    // R2: a response right after an idle acceptance is always a decode error
    assert_decode_rsp_err_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_valid && !busy)) |-> rsp_err);

    // R5: master abort completes cleanly, reads return all ones
    assert_mabort_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(busy && term_valid && term_code == TERM_MABORT))
        |-> (!rsp_err && (!$past(rd_pending) || rsp_rdata == '1)));

    // R6: every bus error leaves a system-level status bit behind
    assert_err_flagged_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (|status[ST_W-1:ST_TA]));

    // R8: status bits drop only when cleared
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~($past(clr_valid) ? $past(clr_mask) : '0) & ~status) == '0));
endmodule

bind obt_term_unit obt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .term_valid  (term_valid),
    .term_code   (term_code),
    .busy        (busy),
    .rd_pending  (rd_q),
    .clr_valid   (clr_valid),
    .clr_mask    (clr_mask),
    .issue_valid (issue_valid),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .status      (status)
);

// File: tb/sim_obt_term_unit.sv
`timescale 1ns/1ps
module sim_obt_term_unit;
    localparam int NWIN = 4;
    localparam int AW   = 32;
    localparam int RW   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_burst = 1'b0;
    logic [NWIN*AW-1:0] win_base;
    logic [NWIN*AW-1:0] win_mask;
    logic [NWIN-1:0]   win_mem = 4'b1101;
    logic [RW-1:0]     retry_limit = 4'd3;
    logic              term_valid = 1'b0;
    logic [1:0]        term_code = 2'd0;
    logic [31:0]       pci_rdata = '0;
    logic [4:0]        irq_en = 5'b11110;
    logic              clr_valid = 1'b0;
    logic [4:0]        clr_mask = '0;
    logic              issue_valid, rsp_valid, rsp_err, pci_irq, sys_err_irq;
    logic [31:0]       rsp_rdata;
    logic [4:0]        status;

    int n_chk = 0;
    int n_bad = 0;

    assign win_base = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
    assign win_mask = {32'h0FFF_FFFF, 32'h0FFF_FFFF, 32'h0000_FFFF, 32'h00FF_FFFF};

    always #5 clk = ~clk;

    obt_term_unit #(.NWIN(NWIN), .AW(AW), .RW(RW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_burst(req_burst), .win_base(win_base),
        .win_mask(win_mask), .win_mem(win_mem), .retry_limit(retry_limit),
        .term_valid(term_valid), .term_code(term_code), .pci_rdata(pci_rdata),
        .irq_en(irq_en), .clr_valid(clr_valid), .clr_mask(clr_mask),
        .issue_valid(issue_valid), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .status(status), .pci_irq(pci_irq),
        .sys_err_irq(sys_err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive one request for one cycle; returns at the negedge after the edge
    task automatic send_req(input logic [31:0] a, input logic wr, input logic bu);
        req_addr = a; req_write = wr; req_burst = bu; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_term(input logic [1:0] c, input logic [31:0] d);
        term_code = c; pci_rdata = d; term_valid = 1'b1;
        @(negedge clk);
        term_valid = 1'b0;
    endtask

    task automatic clear(input logic [4:0] m);
        clr_mask = m; clr_valid = 1'b1;
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1 issue_valid", 32'(issue_valid), 32'h0);
        chk("R1 irqs", {30'h0, pci_irq, sys_err_irq}, 32'h0);
    endtask

    task automatic t_normal;
        send_req(32'h1000_0040, 1'b0, 1'b0);
        chk("R2 issue on hit", 32'(issue_valid), 32'h1);
        chk("R2 no rsp on hit", 32'(rsp_valid), 32'h0);
        send_term(2'd0, 32'hA5A5_1234);
        chk("R4 rsp_valid", 32'(rsp_valid), 32'h1);
        chk("R4 rsp_err", 32'(rsp_err), 32'h0);
        chk("R4 read data", rsp_rdata, 32'hA5A5_1234);
        chk("R4 issue low", 32'(issue_valid), 32'h0);
        send_req(32'h3000_0100, 1'b1, 1'b1);
        chk("R3 burst to mem issues", 32'(issue_valid), 32'h1);
        send_term(2'd0, 32'hDEAD_BEEF);
        chk("R4 write data zero", rsp_rdata, 32'h0);
        chk("R10 one rsp", 32'(rsp_valid), 32'h1);
        @(negedge clk);
        chk("R10 no second rsp", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_nohit;
        send_req(32'h5000_0000, 1'b0, 1'b0);
        chk("R2 nohit rsp_valid", 32'(rsp_valid), 32'h1);
        chk("R2 nohit rsp_err", 32'(rsp_err), 32'h1);
        chk("R2 nohit no issue", 32'(issue_valid), 32'h0);
        chk("R2 nohit status", 32'(status), 32'h08);
        chk("R9 sys irq nohit", 32'(sys_err_irq), 32'h1);
        chk("R9 pci irq low", 32'(pci_irq), 32'h0);
    endtask

    task automatic t_unsup;
        send_req(32'h2000_0010, 1'b0, 1'b1);
        chk("R3 burst io err", {30'h0, rsp_valid, rsp_err}, 32'h3);
        chk("R3 unsup status", 32'(status), 32'h18);
        chk("R9 unsup no pci irq", 32'(pci_irq), 32'h0);
        send_req(32'h2000_0010, 1'b0, 1'b0);
        chk("R3 single io issues", 32'(issue_valid), 32'h1);
        send_term(2'd0, 32'h0000_00AB);
        chk("R3 single io completes", {30'h0, rsp_valid, rsp_err}, 32'h2);
    endtask

    task automatic t_mabort;
        send_req(32'h4000_0000, 1'b0, 1'b0);
        send_term(2'd1, 32'h1234_5678);
        chk("R5 ma rsp clean", {30'h0, rsp_valid, rsp_err}, 32'h2);
        chk("R5 ma all ones", rsp_rdata, 32'hFFFF_FFFF);
        chk("R5 ma status", 32'(status[0]), 32'h1);
        chk("R9 ma disabled", 32'(pci_irq), 32'h0);
        irq_en = 5'b11111;
        #1;
        chk("R9 ma enabled", 32'(pci_irq), 32'h1);
        send_req(32'h4000_0008, 1'b1, 1'b0);
        send_term(2'd1, 32'h0);
        chk("R5 ma write clean", {30'h0, rsp_valid, rsp_err}, 32'h2);
        chk("R5 ma write data", rsp_rdata, 32'h0);
    endtask

    task automatic t_tabort;
        send_req(32'h1000_0000, 1'b0, 1'b0);
        send_term(2'd2, 32'h0);
        chk("R6 ta err", {30'h0, rsp_valid, rsp_err}, 32'h3);
        chk("R6 ta status", 32'(status[1]), 32'h1);
    endtask

    task automatic t_retry;
        retry_limit = 4'd3;
        send_req(32'h1000_0000, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) begin
            send_term(2'd3, 32'h0);
            chk("R7 retry reissue", 32'(issue_valid), 32'h1);
            chk("R7 retry no rsp", 32'(rsp_valid), 32'h0);
            chk("R7 retry no status", 32'(status[2]), 32'h0);
        end
        send_term(2'd3, 32'h0);
        chk("R7 limit err", {30'h0, rsp_valid, rsp_err}, 32'h3);
        chk("R7 limit status", 32'(status[2]), 32'h1);
        chk("R7 no reissue", 32'(issue_valid), 32'h0);
        clear(5'b00100);
        send_req(32'h1000_0000, 1'b0, 1'b0);
        send_term(2'd3, 32'h0);
        chk("R7 reload reissue", 32'(issue_valid), 32'h1);
        send_term(2'd3, 32'h0);
        chk("R7 reload 2nd no rsp", 32'(rsp_valid), 32'h0);
        send_term(2'd0, 32'h0000_0077);
        chk("R7 reload completes", rsp_rdata, 32'h0000_0077);
        chk("R7 reload status", 32'(status[2]), 32'h0);
    endtask

    task automatic t_w1c;
        chk("R8 all sticky", 32'(status), 32'h1B);
        clear(5'b01000);
        chk("R8 clear one", 32'(status), 32'h13);
        clear(5'b11111);
        chk("R8 clear all", 32'(status), 32'h0);
        chk("R9 irqs drop", {30'h0, pci_irq, sys_err_irq}, 32'h0);
        clr_mask = 5'b01000; clr_valid = 1'b1;
        send_req(32'h6000_0000, 1'b0, 1'b0);
        clr_valid = 1'b0;
        chk("R8 set wins", 32'(status), 32'h08);
        clear(5'b11111);
    endtask

    task automatic t_ignore;
        send_req(32'h1000_0000, 1'b0, 1'b0);
        send_req(32'h7000_0000, 1'b0, 1'b0);
        chk("R10 busy req no rsp", 32'(rsp_valid), 32'h0);
        chk("R10 busy req no status", 32'(status), 32'h0);
        send_term(2'd0, 32'h0000_0055);
        chk("R10 single rsp", {30'h0, rsp_valid, rsp_err}, 32'h2);
        send_term(2'd2, 32'h0);
        chk("R10 idle term ignored", 32'(rsp_valid), 32'h0);
        chk("R10 idle term no status", 32'(status), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_nohit();
        t_unsup();
        t_mabort();
        t_tabort();
        t_retry();
        t_w1c();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule